// File: doc/BRIEF.md
# SPI Master with Programmable Frame Length

This block is an SPI-style master shift engine with a small register interface. Software loads an 8-bit shift register and selects the bit rate and the frame length. It also picks the clock polarity and phase, then sets a run bit to start a frame. The bit clock is the core clock divided by a fixed prescaler of 13 and then by a selectable power-of-two factor. Every bit lasts one full bit-clock period, and the two SCK edges of a bit fall half a period apart.

The frame length runs from 1 to 15 bits and does not depend on the register width. A frame longer than 8 bits therefore moves extra bits through the register. The register keeps only the last 8 bits received, and the output sends zeros once the 8 loaded bits are gone. Hardware clears the run bit after the last bit. If interrupts are enabled, it also sets a flag that software may clear but never set. While a frame runs, register writes to the format, data and mode registers are ignored. A separate select bit decides whether the serial output pin carries shift data or a general-purpose level.

Top module: `spi_frame_master`

## Requirements
- R1: After reset the format register (address 1) reads 00h, the mode register (address 2) reads 00h, the select register (address 3) reads 00h, irq is 0, sck is 0 and sout follows gpio_level.
- R2: The rate field, bits 2:0 of address 1, sets the bit period. The period is 13 core cycles times 1, 2, 4, 8, 16, 32, 64 or 256 for codes 0 to 7. A frame of n bits keeps the run bit, bit 0 of address 2, at 1 for exactly n periods.
- R3: The length field, bits 6:3 of address 1, gives the number of bits per frame, from 1 to 15. With length 0, writing run as 1 leaves run at 0 and starts nothing.
- R4: sout sends the loaded byte most significant bit first, one bit per period. Bits beyond the eighth are sent as 0.
- R5: In the middle of each bit, at the sampling SCK edge, sin is sampled and shifted into bit 0 of the data register (address 0). After an n-bit frame the register holds the loaded byte shifted left by n with the received bits appended, so a frame of more than 8 bits leaves only the last 8 received bits.
- R6: sck rests at CPOL (bit 2 of address 2) while idle. During a bit with CPHA (bit 3 of address 2) at 0, sck is CPOL in the first half and inverted in the second half. With CPHA at 1 the two halves swap.
- R7: The flag, bit 7 of address 1, is set at the end of a frame only when the interrupt enable (bit 1 of address 2) is 1. Writing 0 to it clears it, and writing 1 has no effect. irq is the flag ANDed with the enable.
- R8: While run is 1, writes to addresses 0, 1 and 2 are ignored.
- R9: Hardware clears run after the last bit of the frame.
- R10: Bit 0 of address 3 is write-only and always reads back 0. When it is clear, sout equals gpio_level. When it is set, sout carries shift data, and while idle that data is bit 7 of the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address (0 data, 1 format, 2 mode, 3 select) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| sin | input | 1 | Serial data in |
| gpio_level | input | 1 | Level driven on sout when shift output is not selected |
| sck | output | 1 | Serial clock |
| sout | output | 1 | Serial data out |
| irq | output | 1 | Interrupt request |

## Verification
Frames are run in all four CPOL/CPHA combinations, with lengths 1, 3, 5, 8, 12 and 15 and with rate codes 0, 1, 2, 3 and 7. A frame length below 8 shows that loaded bits are kept, while lengths above 8 show that only the last 8 received bits survive and that the tail is sent as zeros. The receive pattern differs in every bit position, so an off-by-one in the sampling point or in the bit count shows up as a different register value. The same is true of a wrong frame duration. Writes issued in the middle of a frame, a zero length, and flag writes of 0 and of 1 separate the lock and the flag rules from the normal path.

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int PRESCALE = 13,
  parameter int MAXSHIFT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sin,
  input  logic       gpio_level,
  output logic       sck,
  output logic       sout,
  output logic       irq
);
  localparam int CW = $clog2(PRESCALE * (1 << MAXSHIFT) + 1);

  logic [7:0]    sr_q;
  logic          flag_q, run_q, ie_q, cpol_q, cpha_q, osel_q, hold_q;
  logic [3:0]    len_q, bit_q;
  logic [2:0]    rate_q;
  logic [CW-1:0] cnt_q;

  logic [3:0]    shamt;
  logic [CW-1:0] period, half;
  logic          bit_end, mid, last_bit, wr_open, second_half;

  assign shamt       = (rate_q == 3'd7) ? 4'(MAXSHIFT) : {1'b0, rate_q};
  assign period      = CW'(PRESCALE) << shamt;
  assign half        = period >> 1;
  assign bit_end     = run_q && (cnt_q == period - CW'(1));
  assign mid         = run_q && (cnt_q == half - CW'(1));
  assign last_bit    = (bit_q == len_q - 4'd1);
  assign wr_open     = reg_wr && !run_q;
  assign second_half = (cnt_q >= half);

  assign sck  = run_q ? (cpol_q ^ (cpha_q ? !second_half : second_half)) : cpol_q;
  assign sout = osel_q ? ((bit_q < 4'd8) ? sr_q[7] : 1'b0) : gpio_level;
  assign irq  = flag_q & ie_q;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = sr_q;
      2'd1:    reg_rdata = {flag_q, len_q, rate_q};
      2'd2:    reg_rdata = {4'd0, cpha_q, cpol_q, ie_q, run_q};
      default: reg_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= 8'd0;
      flag_q <= 1'b0;
      len_q  <= 4'd0;
      rate_q <= 3'd0;
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      osel_q <= 1'b0;
      hold_q <= 1'b0;
      bit_q  <= 4'd0;
      cnt_q  <= '0;
    end else begin
      if (reg_wr && reg_addr == 2'd3)
        osel_q <= reg_wdata[0];
      if (wr_open) begin
        case (reg_addr)
          2'd0: sr_q <= reg_wdata;
          2'd1: begin
            flag_q <= flag_q & reg_wdata[7];
            len_q  <= reg_wdata[6:3];
            rate_q <= reg_wdata[2:0];
          end
          2'd2: begin
            cpha_q <= reg_wdata[3];
            cpol_q <= reg_wdata[2];
            ie_q   <= reg_wdata[1];
            if (reg_wdata[0] && len_q != 4'd0) begin
              run_q <= 1'b1;
              cnt_q <= '0;
              bit_q <= 4'd0;
            end
          end
          default: ;
        endcase
      end
      if (run_q) begin
        if (mid)
          hold_q <= sin;
        if (bit_end) begin
          cnt_q <= '0;
          sr_q  <= {sr_q[6:0], hold_q};
          if (last_bit) begin
            run_q <= 1'b0;
            bit_q <= 4'd0;
            if (ie_q) flag_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 4'd1;
          end
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  AST_IDLE_SCK: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> sck == cpol_q);  // R6
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(run_q) && ie_q);  // R7
  AST_FORMAT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && $past(run_q) |-> $stable(len_q) && $stable(rate_q) && $stable(cpol_q) && $stable(cpha_q));  // R8
  AST_LEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> len_q != 4'd0);  // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q < period);  // R2
  AST_RUN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> $past(bit_q) == len_q - 4'd1);  // R9
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && osel_q && bit_q >= 4'd8 |-> !sout);  // R4
endmodule

// File: tb/spi_frame_master_test.sv
module spi_frame_master_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       sin = 1'b0;
  logic       gpio_level = 1'b0;
  logic       sck, sout, irq;

  int total = 0;
  int bad = 0;

  logic        slave_on = 1'b0;
  logic        cur_cpol = 1'b0;
  logic        cur_cpha = 1'b0;
  logic [15:0] pat_q = 16'd0;
  logic [15:0] got_out = 16'd0;
  int          idx = 0;
  logic        samp;

  spi_frame_master uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sin(sin),
    .gpio_level(gpio_level), .sck(sck), .sout(sout), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign samp = sck ^ cur_cpol ^ cur_cpha;

  always @(posedge samp) begin
    if (slave_on) begin
      got_out = {got_out[14:0], sout};
      idx = idx + 1;
      #1;
      if (idx < 16) sin = pat_q[15 - idx];
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    read_reg(2'd1, v); check("R1 format reg", v, 8'h00);
    read_reg(2'd2, v); check("R1 mode reg", v, 8'h00);
    read_reg(2'd3, v); check("R1 select reg", v, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 sck", sck, 0);
    gpio_level = 1'b1; #1;
    check("R1 sout follows gpio", sout, 1);
    gpio_level = 1'b0;
  endtask

  task automatic t_frame(input logic cpol, input logic cpha, input logic [2:0] rate,
                         input logic [3:0] len, input logic [7:0] tx,
                         input logic [15:0] pat, input logic ie);
    logic [7:0]  v, exp_sr;
    logic [15:0] exp_out;
    int n, per;
    write_reg(2'd3, 8'h01);
    write_reg(2'd1, {1'b0, len, rate});
    write_reg(2'd0, tx);
    write_reg(2'd2, {4'd0, cpha, cpol, ie, 1'b0});
    #1;
    check("R6 idle sck at cpol", sck, cpol);
    cur_cpol = cpol; cur_cpha = cpha;
    pat_q = pat; idx = 0; got_out = 16'd0; sin = pat[15];
    #1;
    slave_on = 1'b1;
    write_reg(2'd2, {4'd0, cpha, cpol, ie, 1'b1});
    #1;
    check("R6 first half sck", sck, cpol ^ cpha);
    n = 0;
    read_reg(2'd2, v);
    while (v[0]) begin
      n++;
      @(negedge clk);
      read_reg(2'd2, v);
    end
    slave_on = 1'b0;
    per = 13 * ((rate == 3'd7) ? 256 : (1 << rate));
    check("R2 frame duration", n, per * len);
    check("R9 run cleared", v[0], 0);
    exp_sr = tx; exp_out = 16'd0;
    for (int i = 0; i < len; i++) begin
      exp_out = {exp_out[14:0], (i < 8) ? tx[7 - i] : 1'b0};
      exp_sr  = {exp_sr[6:0], pat[15 - i]};
    end
    check("R4 serial out bits", got_out, exp_out);
    check("R3 bit count", idx, len);
    read_reg(2'd0, v); check("R5 received data", v, exp_sr);
    read_reg(2'd1, v); check("R7 flag after frame", v[7], ie);
    check("R7 irq", irq, ie);
    check("R6 sck back at cpol", sck, cpol);
  endtask

  task automatic t_lock();
    logic [7:0] v;
    int n;
    write_reg(2'd1, {1'b0, 4'd4, 3'd1});
    write_reg(2'd0, 8'hA5);
    sin = 1'b0;
    write_reg(2'd2, 8'h03);
    write_reg(2'd0, 8'h11);
    write_reg(2'd1, 8'h7F);
    write_reg(2'd2, 8'h0C);
    read_reg(2'd2, v); check("R8 mode write ignored", v, 8'h03);
    n = 0;
    while (v[0] && n < 1000) begin
      n++;
      @(negedge clk);
      read_reg(2'd2, v);
    end
    read_reg(2'd1, v); check("R8 format write ignored", v, {1'b1, 4'd4, 3'd1});
    read_reg(2'd0, v); check("R8 data write ignored", v, 8'h50);
  endtask

  task automatic t_flag();
    logic [7:0] v;
    write_reg(2'd1, {1'b1, 4'd4, 3'd1});
    read_reg(2'd1, v); check("R7 writing 1 keeps flag", v[7], 1);
    check("R7 irq held", irq, 1);
    write_reg(2'd1, {1'b0, 4'd4, 3'd1});
    read_reg(2'd1, v); check("R7 writing 0 clears flag", v[7], 0);
    check("R7 irq cleared", irq, 0);
    write_reg(2'd1, {1'b1, 4'd4, 3'd1});
    read_reg(2'd1, v); check("R7 software cannot set flag", v[7], 0);
  endtask

  task automatic t_len0();
    logic [7:0] v;
    write_reg(2'd1, 8'h00);
    write_reg(2'd2, 8'h01);
    read_reg(2'd2, v); check("R3 zero length does not start", v[0], 0);
    @(negedge clk);
    read_reg(2'd2, v); check("R3 still idle", v[0], 0);
  endtask

  task automatic t_outsel();
    logic [7:0] v;
    write_reg(2'd3, 8'h00);
    gpio_level = 1'b1; #1;
    check("R10 gpio on sout high", sout, 1);
    gpio_level = 1'b0; #1;
    check("R10 gpio on sout low", sout, 0);
    write_reg(2'd0, 8'h80);
    write_reg(2'd3, 8'h01);
    #1;
    check("R10 shift data on sout", sout, 1);
    read_reg(2'd3, v); check("R10 select reads zero", v, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame(1'b0, 1'b0, 3'd0, 4'd8,  8'hA5, 16'h3C00, 1'b1);
    t_frame(1'b1, 1'b1, 3'd1, 4'd5,  8'hC3, 16'hB000, 1'b1);
    t_frame(1'b0, 1'b1, 3'd2, 4'd12, 8'h5A, 16'hD2B0, 1'b0);
    t_frame(1'b1, 1'b0, 3'd0, 4'd15, 8'hF0, 16'h9AC6, 1'b1);
    t_frame(1'b0, 1'b0, 3'd7, 4'd1,  8'h80, 16'h0000, 1'b1);
    t_frame(1'b0, 1'b0, 3'd3, 4'd3,  8'h6E, 16'hA000, 1'b0);
    t_lock();
    t_flag();
    t_len0();
    t_outsel();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule